// File: doc/BRIEF.md
# GPIO Event Detect Interrupt Unit

This block watches up to 58 general-purpose input pins and records events on them in a sticky status register. Software then combines those events into three interrupt lines. Each pin has six enable bits, one for each detection kind. Synchronous rising and falling edges are found on the synchronised pin value. High and low levels are found on the same value. Early rising and falling edges are found on the first synchroniser stage, so they arrive one cycle sooner. Setting both edge enables of one kind detects both edges.

Each status bit stays set until software writes a one to it. The interrupt lines are plain ORs over fixed pin ranges. Those ranges split the pins at 28 and at 46, so the middle line takes the top four bits of the first 32-bit bank and the low fourteen bits of the second bank.

All registers are reached through a single-cycle register bus with combinational read data. The pins pass through a two-flop synchroniser inside the block.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, every enable register and every status bit reads zero, and `irq` is 3'b000.
- R2: A bus write sets one enable register. Bank 0 and bank 1 are 4 bytes apart. The addresses are: rising 0x4C/0x50, falling 0x58/0x5C, high level 0x64/0x68, low level 0x70/0x74, early rising 0x7C/0x80, early falling 0x88/0x8C. The status register is at 0x40/0x44. Every register reads back its contents, and any other address reads zero. Pin n maps to bank n/32, bit n%32.
- R3: With the rising (or falling) enable set, a 0→1 (or 1→0) change on a pin that is stable before clock edge k sets the pin's status bit at edge k+2.
- R4: With both the rising and falling enables set, each edge of the pin sets the status bit.
- R5: With the high (or low) level enable set, the status bit is set at every edge from k+2 on while the level holds, so it comes back right after a clear.
- R6: With an early edge enable set, the status bit is set at edge k+1, one cycle ahead of R3.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If a new event for a bit and a clear of that bit fall in the same cycle, the bit stays set.
- R9: A latched bit stays set after its enable is removed, until it is cleared.
- R10: `irq[0]` is high when any status bit of pins 0..27 is set.
- R11: `irq[1]` is high when any status bit of pins 28..45 is set. This range spans both banks.
- R12: `irq[2]` is high when any status bit of pins 46..57 is set.
- R13: Bank-1 bits 26..31 (pins 58..63) are not implemented. They read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw pin levels |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 3 | Interrupt lines for the three pin ranges |

## Verification
The bench builds the block with its defaults: 58 pins and interrupt splits at 28 and 46. This gives a partly filled second bank, so the unused bits 58..63 can be tested. It also makes the middle interrupt line cross the bank boundary, so events on both sides of that boundary are exercised. Directed sequences check the edge, level and early-edge latencies, a clear landing in the same cycle as a new event, and status that stays set after its enable is removed. Random pin toggles and register writes then run against a cycle model in the bench.

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int NPINS   = 58,
  parameter int IRQ1_LO = 28,
  parameter int IRQ2_LO = 46
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [2:0]       irq
);
  localparam int NBANK  = (NPINS + 31) / 32;
  localparam int W      = NBANK * 32;
  localparam int STAT_A = 'h40;
  localparam int STRIDE = 12;
  localparam logic [W-1:0] PMASK = {W{1'b1}} >> (W - NPINS);

  // 0 rise, 1 fall, 2 high, 3 low, 4 early rise, 5 early fall
  logic [W-1:0] en_q [6];
  logic [W-1:0] st_q, s1_q, s2_q, prev_q;
  logic [W-1:0] ev, clr;

  assign ev = (en_q[0] &  s2_q & ~prev_q) | (en_q[1] & ~s2_q & prev_q)
            | (en_q[2] &  s2_q)           | (en_q[3] & ~s2_q & PMASK)
            | (en_q[4] &  s1_q & ~s2_q)   | (en_q[5] & ~s1_q & s2_q);

  always_comb begin
    clr = '0;
    for (int b = 0; b < NBANK; b++)
      if (bus_wr && bus_addr == 8'(STAT_A + 4*b))
        clr[b*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      for (int k = 0; k < 6; k++) en_q[k] <= '0;
    end else begin
      s1_q   <= W'(pin_in);
      s2_q   <= s1_q;
      prev_q <= s2_q;
      st_q   <= ((st_q & ~clr) | ev) & PMASK;
      for (int k = 0; k < 6; k++)
        for (int b = 0; b < NBANK; b++)
          if (bus_wr && bus_addr == 8'(STAT_A + STRIDE*(k+1) + 4*b))
            en_q[k][b*32 +: 32] <= bus_wdata & PMASK[b*32 +: 32];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == 8'(STAT_A + 4*b)) bus_rdata = st_q[b*32 +: 32];
      for (int k = 0; k < 6; k++)
        if (bus_addr == 8'(STAT_A + STRIDE*(k+1) + 4*b))
          bus_rdata = en_q[k][b*32 +: 32];
    end
  end

  assign irq[0] = |st_q[IRQ1_LO-1:0];
  assign irq[1] = |st_q[IRQ2_LO-1:IRQ1_LO];
  assign irq[2] = |st_q[NPINS-1:IRQ2_LO];
endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk #(
  parameter int W  = 64,
  parameter int L1 = 28
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] st,
  input logic [W-1:0] ev,
  input logic [W-1:0] clr,
  input logic         bus_wr,
  input logic [7:0]   bus_addr,
  input logic [31:0]  bus_rdata,
  input logic [2:0]   irq
);
  // R1
  reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> irq == 3'b000);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev != '0 |=> (st & $past(ev)) == $past(ev));

  // R9
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(st) & ~$past(clr) & ~st) == '0);

  // R7
  clear_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !ev[0]) |=> !st[0]);

  // R10
  irq0_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && bus_addr == 8'h40) |-> irq[0] == (|bus_rdata[L1-1:0]));
endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(.W(W), .L1(IRQ1_LO)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st_q), .ev(ev), .clr(clr),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/gpio_evt_unit_test.sv
`timescale 1ns/100ps
module gpio_evt_unit_test;
  localparam logic [63:0] PM = 64'h03FF_FFFF_FFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic [57:0] pin_in = '0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 8'h40;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] irq;
  int vecs = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_en [6];
  logic [63:0] m_st, m_s1, m_s2, m_pv, cur_p;

  always #2.5 clk = ~clk;

  gpio_evt_unit uut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h40) return m_st[31:0];
    if (a == 8'h44) return m_st[63:32];
    for (int k = 0; k < 6; k++) begin
      if (a == 8'(8'h4C + 12*k)) return m_en[k][31:0];
      if (a == 8'(8'h50 + 12*k)) return m_en[k][63:32];
    end
    return 32'h0;
  endfunction

  function automatic logic [2:0] m_irq();
    return {|m_st[57:46], |m_st[45:28], |m_st[27:0]};
  endfunction

  function automatic logic [7:0] addr_of(input int idx);
    if (idx >= 14) return 8'h3C;
    return 8'(8'h40 + 12*(idx/2) + 4*(idx%2));
  endfunction

  task automatic m_clock(input logic [63:0] p, input logic w, input logic [7:0] a, input logic [31:0] d);
    logic [63:0] ev, clr;
    ev = (m_en[0] & m_s2 & ~m_pv) | (m_en[1] & ~m_s2 & m_pv) | (m_en[2] & m_s2)
       | (m_en[3] & ~m_s2 & PM) | (m_en[4] & m_s1 & ~m_s2) | (m_en[5] & ~m_s1 & m_s2);
    clr = '0;
    if (w && a == 8'h40) clr[31:0]  = d;
    if (w && a == 8'h44) clr[63:32] = d;
    m_st = ((m_st & ~clr) | ev) & PM;
    for (int k = 0; k < 6; k++) begin
      if (w && a == 8'(8'h4C + 12*k)) m_en[k][31:0]  = d;
      if (w && a == 8'(8'h50 + 12*k)) m_en[k][63:32] = d & PM[63:32];
    end
    m_pv = m_s2; m_s2 = m_s1; m_s1 = p & PM;
  endtask

  task automatic step(input logic [63:0] p, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic [2:0] ei;
    @(negedge clk);
    pin_in = p[57:0]; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    er = m_read(a); ei = m_irq();
    vecs++;
    if (bus_rdata !== er) begin
      fails++;
      $display("FAIL %s rdata @%h: got %h expected %h", tag, a, bus_rdata, er);
    end
    vecs++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, ei);
    end
    @(posedge clk);
    m_clock(p, w, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(cur_p, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(cur_p, 1'b1, a, d, tag);
  endtask

  task automatic pins(input logic [63:0] p, input logic [7:0] a, input string tag);
    cur_p = p;
    step(cur_p, 1'b0, a, 32'h0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    m_st = '0; m_s1 = '0; m_s2 = '0; m_pv = '0; cur_p = '0;
    for (int k = 0; k < 6; k++) m_en[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    for (int i = 0; i < 15; i++) rd(addr_of(i), "R1");

    // R2 / R13: register map and unimplemented high bits
    for (int i = 2; i < 14; i++) wr(addr_of(i), 32'hFFFF_FFFF, "R2");
    for (int i = 0; i < 15; i++) rd(addr_of(i), "R13");
    for (int i = 2; i < 14; i++) wr(addr_of(i), 32'h0, "R2");
    wr(8'h3C, 32'hFFFF_FFFF, "R2");
    rd(8'h3C, "R2");

    // R3: synchronous rising edge latency on pin 0
    wr(8'h4C, 32'h1, "R3");
    pins(64'h1, 8'h40, "R3");
    rd(8'h40, "R3"); rd(8'h40, "R3"); rd(8'h40, "R3");
    wr(8'h40, 32'h1, "R7");
    rd(8'h40, "R7");
    // R4: both edges
    wr(8'h58, 32'h1, "R4");
    pins(64'h0, 8'h40, "R4");
    rd(8'h40, "R4"); rd(8'h40, "R4"); rd(8'h40, "R4");
    wr(8'h40, 32'h0, "R7");
    wr(8'h40, 32'h1, "R7");
    pins(64'h1, 8'h40, "R4");
    rd(8'h40, "R4"); rd(8'h40, "R4"); rd(8'h40, "R4");
    // R9: remove enables, status stays
    wr(8'h4C, 32'h0, "R9"); wr(8'h58, 32'h0, "R9");
    rd(8'h40, "R9"); rd(8'h40, "R9");
    wr(8'h40, 32'h1, "R7");
    rd(8'h40, "R7");

    // R5 / R8: level high on pin 1 re-asserts; clear loses to event
    wr(8'h64, 32'h2, "R5");
    pins(64'h3, 8'h40, "R5");
    rd(8'h40, "R5"); rd(8'h40, "R5");
    wr(8'h40, 32'h2, "R8");
    rd(8'h40, "R8");
    wr(8'h64, 32'h0, "R5");
    wr(8'h40, 32'h2, "R5");
    rd(8'h40, "R5");
    // R5: low level on pin 2
    wr(8'h70, 32'h4, "R5");
    rd(8'h40, "R5"); rd(8'h40, "R5");
    wr(8'h70, 32'h0, "R5");
    wr(8'h40, 32'hFFFF_FFFF, "R7");
    rd(8'h40, "R7");

    // R6: early edges on pin 33, compare with sync rising on pin 34
    wr(8'h80, 32'h2, "R6"); wr(8'h8C, 32'h2, "R6"); wr(8'h50, 32'h4, "R6");
    pins(64'h6_0000_0003, 8'h44, "R6");
    rd(8'h44, "R6"); rd(8'h44, "R6"); rd(8'h44, "R6");
    pins(64'h3, 8'h44, "R6");
    rd(8'h44, "R6"); rd(8'h44, "R6");
    wr(8'h80, 32'h0, "R6"); wr(8'h8C, 32'h0, "R6"); wr(8'h50, 32'h0, "R6");
    wr(8'h44, 32'hFFFF_FFFF, "R7");
    rd(8'h44, "R7");

    // R10 / R11 / R12: interrupt ranges at each boundary
    wr(8'h64, 32'hFFFF_FFFF, "R10"); wr(8'h68, 32'hFFFF_FFFF, "R11");
    pins(64'h0, 8'h40, "R10"); wr(8'h40, 32'hFFFF_FFFF, "R10"); rd(8'h40, "R10");
    begin
      int pl [6] = '{27, 28, 31, 32, 45, 46};
      foreach (pl[j]) begin
        pins(64'h1 << pl[j], 8'h40, "R11");
        rd(8'h44, "R11"); rd(8'h40, "R11");
        pins(64'h0, 8'h40, "R12");
        rd(8'h44, "R12");
        wr(8'h40, 32'hFFFF_FFFF, "R12"); wr(8'h44, 32'hFFFF_FFFF, "R12");
        rd(8'h44, "R12");
      end
    end
    pins(64'h1 << 57, 8'h44, "R12"); rd(8'h44, "R12"); rd(8'h44, "R12");
    wr(8'h64, 32'h0, "R10"); wr(8'h68, 32'h0, "R11");
    wr(8'h44, 32'hFFFF_FFFF, "R12"); rd(8'h44, "R12");

    // random mix: R3..R12 against the bench model
    for (int n = 0; n < 6000; n++) begin
      logic [63:0] flip;
      int sel;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cur_p = (cur_p ^ flip) & PM;
      sel = $urandom_range(0, 9);
      if (sel < 2)
        step(cur_p, 1'b1, addr_of($urandom_range(2, 13)), $urandom & $urandom & $urandom, "R2");
      else if (sel < 4)
        step(cur_p, 1'b1, addr_of($urandom_range(0, 1)), $urandom | $urandom, "R7");
      else
        step(cur_p, 1'b0, addr_of($urandom_range(0, 14)), 32'h0, "R3");
    end
    summary();
  end
endmodule